// File: doc/BRIEF.md
# Coincident Edge Negotiation Detector

This block watches two asynchronous control lines of a host parallel port. The select line is active high and the strobe line is active low; on the port's wires they idle low and high respectively. In ordinary transfers the host moves only one of the two at a time. The block therefore treats the select line rising together with the strobe line falling as a separate protocol event: the host is asking to negotiate a new transfer mode.

Both lines are synchronized to the system clock and compared with their previous synchronized sample. A rise of select together with a fall of strobe, in the same sample or within a window of `WIN` samples, sets a sticky negotiation flag. The flag stays high until a clear input or reset. A fall of strobe that is not coincident is reported as a single-cycle strobe. It is a nibble-read strobe when select is high and unchanged, and a compatibility-write strobe when select is low. Downstream logic uses the flag to leave the current transfer mode and start the negotiation handshake.

Top module: `nego_detect`

## Requirements
- R1: While `rst_n` is low, `nego_flag_o`, `nib_rd_o` and `cmp_wr_o` are all 0.
- R2: For the first `SYNC_STAGES`+1 clock edges after reset release, no output pulses or flag sets, whatever the levels on the lines. Levels present at reset never appear as edges.
- R3: A change on the raw lines that is first sampled at clock edge j is reported on the outputs registered at edge j+2, with the default `SYNC_STAGES` = 2.
- R4: When select goes 0→1 in the same synchronized sample in which strobe goes 1→0, `nego_flag_o` becomes 1 and neither strobe output pulses for that sample.
- R5: A strobe fall counts as coincident only if select rose in the same sample or within the `WIN`-1 samples before it and is still high. With the default `WIN` = 1, a strobe fall one sample after a select rise is an ordinary nibble-read strobe.
- R6: A strobe 1→0 edge while select is 1 and unchanged gives a one-cycle pulse on `nib_rd_o`.
- R7: A strobe 1→0 edge while select is 0 in that sample gives a one-cycle pulse on `cmp_wr_o`. This includes the case where select falls in the same sample.
- R8: A select edge with no strobe fall, and a strobe 0→1 edge, produce no pulse and do not change the flag.
- R9: `nego_flag_o` stays 1 until `nego_clr_i` is sampled high. A clear with no coincident event in the same sample drives the flag to 0 on that edge. A coincident event wins over a clear in the same sample.
- R10: `nib_rd_o` and `cmp_wr_o` are never high together, and each is high for one cycle at a time.
- R11: While the flag is held high, later non-coincident strobe falls still produce their normal strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sel_i | input | 1 | Raw select line, active high, asynchronous |
| host_strb_n_i | input | 1 | Raw strobe line, active low, asynchronous |
| nego_clr_i | input | 1 | Synchronous clear of the negotiation flag |
| nego_flag_o | output | 1 | Sticky negotiation-request flag |
| nib_rd_o | output | 1 | One-cycle nibble-read strobe |
| cmp_wr_o | output | 1 | One-cycle compatibility-write strobe |

## Verification
The assertions assume that the raw lines are slow compared with the clock. Each level is assumed to persist for at least one clock, so that no edge falls between two synchronized samples and is lost. The assertions also assume that the reset release is already aligned to the clock. The stimulus changes the lines only on the falling clock edge and holds every level for one to several cycles. Random steps move one line, both lines or neither, and pulse the clear now and then. Directed steps cover coincidence, the one-sample-late strobe, a clear arriving with a new event, and non-idle levels during reset.

// File: rtl/nego_pkg.sv
package nego_pkg;

  // Decision taken for one synchronized sample of the two lines
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_NIBBLE = 2'd1,
    EV_COMPAT = 2'd2,
    EV_NEGO   = 2'd3
  } line_event_e;

  typedef struct packed {
    logic sel;    // active high select level
    logic strb_n; // active low strobe level
  } line_pair_t;

endpackage

// File: rtl/nego_sync.sv
module nego_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nego_edge_win.sv
module nego_edge_win
  import nego_pkg::*;
#(
  parameter int WIN  = 1,
  parameter int WARM = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  line_pair_t   cur_i,
  output line_event_e  ev_o
);

  localparam int AGE_W  = $clog2(WIN + 1);
  localparam int WARM_W = $clog2(WARM + 1);
  localparam logic [AGE_W-1:0]  AGE_MAX  = AGE_W'(WIN);
  localparam logic [AGE_W-1:0]  AGE_LIM  = AGE_W'(WIN - 1);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(WARM);

  line_pair_t          prv_q, prv_d;
  logic [AGE_W-1:0]    age_q, age_d;
  logic [WARM_W-1:0]   warm_q, warm_d;
  logic                warm_en;
  logic                armed;
  logic                sel_chg, strb_chg, xor_same, both_chg;
  logic                sel_rise, strb_fall, sel_recent;
  logic                same_sample, coinc;

  // next-state logic
  always_comb begin
    prv_d    = cur_i;
    armed    = (warm_q == WARM_END);
    warm_en  = !armed;
    warm_d   = warm_q + 1'b1;

    sel_chg  = cur_i.sel ^ prv_q.sel;
    strb_chg = cur_i.strb_n ^ prv_q.strb_n;
    xor_same = (cur_i.sel ^ cur_i.strb_n) == (prv_q.sel ^ prv_q.strb_n);
    both_chg = (sel_chg | strb_chg) & xor_same;

    sel_rise  = armed & sel_chg & cur_i.sel;
    strb_fall = armed & strb_chg & ~cur_i.strb_n;

    sel_recent  = (age_q < AGE_LIM) & cur_i.sel;
    same_sample = armed & both_chg & cur_i.sel & ~cur_i.strb_n;
    coinc       = same_sample | (strb_fall & sel_recent);

    if (sel_rise)              age_d = '0;
    else if (age_q != AGE_MAX) age_d = age_q + 1'b1;
    else                       age_d = age_q;

    if (coinc)                              ev_o = EV_NEGO;
    else if (strb_fall & cur_i.sel & ~sel_chg) ev_o = EV_NIBBLE;
    else if (strb_fall & ~cur_i.sel)        ev_o = EV_COMPAT;
    else                                    ev_o = EV_NONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q <= '0;
      age_q <= AGE_MAX;
    end else begin
      prv_q <= prv_d;
      age_q <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warm_q <= '0;
    else if (warm_en) warm_q <= warm_d;
  end

endmodule

// File: rtl/nego_out_reg.sv
module nego_out_reg
  import nego_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  line_event_e ev_i,
  input  logic        clr_i,
  output logic        flag_o,
  output logic        nib_o,
  output logic        cmp_o
);

  logic flag_q, flag_d;
  logic nib_q, nib_d;
  logic cmp_q, cmp_d;

  always_comb begin
    if (ev_i == EV_NEGO) flag_d = 1'b1;
    else if (clr_i)      flag_d = 1'b0;
    else                 flag_d = flag_q;
    nib_d = (ev_i == EV_NIBBLE);
    cmp_d = (ev_i == EV_COMPAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      nib_q  <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      nib_q  <= nib_d;
      cmp_q  <= cmp_d;
    end
  end

  assign flag_o = flag_q;
  assign nib_o  = nib_q;
  assign cmp_o  = cmp_q;

endmodule

// File: rtl/nego_detect.sv
module nego_detect
  import nego_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN         = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_sel_i,
  input  logic host_strb_n_i,
  input  logic nego_clr_i,
  output logic nego_flag_o,
  output logic nib_rd_o,
  output logic cmp_wr_o
);

  localparam int WARM = SYNC_STAGES + 1;

  line_pair_t  cur;
  logic        sel_s;
  logic        strb_s;
  line_event_e evt;
  logic        nego_set;

  nego_sync #(.STAGES(SYNC_STAGES)) u_sync_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (host_sel_i),
    .q_o  (sel_s)
  );

  nego_sync #(.STAGES(SYNC_STAGES)) u_sync_strb (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (host_strb_n_i),
    .q_o  (strb_s)
  );

  always_comb begin
    cur.sel    = sel_s;
    cur.strb_n = strb_s;
  end

  nego_edge_win #(.WIN(WIN), .WARM(WARM)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .cur_i(cur),
    .ev_o (evt)
  );

  assign nego_set = (evt == EV_NEGO);

  nego_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (evt),
    .clr_i (nego_clr_i),
    .flag_o(nego_flag_o),
    .nib_o (nib_rd_o),
    .cmp_o (cmp_wr_o)
  );

endmodule

// File: rtl/nego_detect_chk.sv
module nego_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_sync,
  input logic set_evt,
  input logic clr,
  input logic flag,
  input logic nib,
  input logic cmp
);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nib, cmp}));

  p_nib_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nib |=> !nib);

  p_cmp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |=> !cmp);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_evt |=> !flag);

  p_set_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag && !nib && !cmp);

  p_nib_sel_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nib |-> $past(sel_sync));

  p_cmp_sel_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |-> !$past(sel_sync));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!flag && !nib && !cmp);
    end
  end

endmodule

bind nego_detect nego_detect_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_sync(sel_s),
  .set_evt (nego_set),
  .clr     (nego_clr_i),
  .flag    (nego_flag_o),
  .nib     (nib_rd_o),
  .cmp     (cmp_wr_o)
);

// File: tb/nego_detect_tb.sv
`timescale 1ns/1ps
module nego_detect_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_i, strb_i, clr_i;
  logic flag_o, nib_o, cmp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  nego_detect u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel_i   (sel_i),
    .host_strb_n_i(strb_i),
    .nego_clr_i   (clr_i),
    .nego_flag_o  (flag_o),
    .nib_rd_o     (nib_o),
    .cmp_wr_o     (cmp_o)
  );

  // Reference model built from the requirements: raw samples per edge,
  // compare sample k-2 with k-3, masked until the fourth edge after reset.
  logic q0, q1, q2, q3, s0, s1, s2, s3;
  int   k;
  logic exp_flag, exp_nib, exp_cmp;

  always @(posedge clk) begin
    logic a_rise, b_fall, valid;
    if (!rst_n) begin
      {q0, q1, q2, q3, s0, s1, s2, s3} = '0;
      k = 0;
      exp_flag = 1'b0; exp_nib = 1'b0; exp_cmp = 1'b0;
    end else begin
      q3 = q2; q2 = q1; q1 = q0; q0 = sel_i;
      s3 = s2; s2 = s1; s1 = s0; s0 = strb_i;
      k = k + 1;
      valid  = (k >= 4);
      a_rise = valid && q2 && !q3;
      b_fall = valid && !s2 && s3;
      exp_nib = b_fall && q2 && !a_rise;
      exp_cmp = b_fall && !q2;
      if (a_rise && b_fall) exp_flag = 1'b1;
      else if (clr_i)       exp_flag = 1'b0;
    end
  end

  task automatic chk(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", flag_o | nib_o | cmp_o, 1'b0, "outputs in reset");
      end else begin
        chk(tag, flag_o, exp_flag, "flag");
        chk(tag, nib_o, exp_nib, "nibble strobe");
        chk(tag, cmp_o, exp_cmp, "compat strobe");
        chk("R10", nib_o & cmp_o, 1'b0, "both strobes");
      end
    end
  end

  task automatic drive(input logic a, input logic b, input int n);
    sel_i = a; strb_i = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sel_i = 1'b1; strb_i = 1'b0; clr_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2: non-idle levels through reset must not read as edges
    tag = "R2";
    drive(1'b1, 1'b0, 6);
    chk("R2", flag_o | nib_o | cmp_o, 1'b0, "after warm-up");
    // R8: select falls, strobe rises together: nothing
    tag = "R8";
    drive(1'b0, 1'b1, 5);
    chk("R8", flag_o, 1'b0, "flag after lone edges");
    drive(1'b1, 1'b1, 5);
    drive(1'b0, 1'b1, 5);
    chk("R8", flag_o, 1'b0, "flag after select pulse");
    // R3/R4: coincident edges, exact latency
    tag = "R4";
    sel_i = 1'b1; strb_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3", flag_o, 1'b0, "flag one edge early");
    @(negedge clk);
    chk("R3", flag_o, 1'b1, "flag at j+2");
    chk("R4", nib_o | cmp_o, 1'b0, "strobes suppressed");
    repeat (4) @(negedge clk);
    chk("R9", flag_o, 1'b1, "flag held");
    // R9: clear
    tag = "R9";
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    chk("R9", flag_o, 1'b0, "flag cleared");
    drive(1'b0, 1'b1, 5);
    // R9: event and clear in the same sample, set wins
    clr_i = 1'b1;
    drive(1'b1, 1'b0, 3);
    chk("R9", flag_o, 1'b1, "set beats clear");
    @(negedge clk);
    chk("R9", flag_o, 1'b0, "clear next sample");
    clr_i = 1'b0;
    drive(1'b0, 1'b1, 5);
    // R6: nibble strobe
    tag = "R6";
    drive(1'b1, 1'b1, 5);
    drive(1'b1, 1'b0, 3);
    chk("R6", nib_o, 1'b1, "nibble pulse");
    @(negedge clk);
    chk("R6", nib_o, 1'b0, "nibble one cycle");
    drive(1'b0, 1'b1, 5);
    // R5: strobe falls one sample after select rises
    tag = "R5";
    drive(1'b1, 1'b1, 1);
    drive(1'b1, 1'b0, 3);
    chk("R5", nib_o, 1'b1, "late fall is nibble");
    chk("R5", flag_o, 1'b0, "late fall no flag");
    drive(1'b0, 1'b1, 5);
    // R7: compat strobe, plain and with select falling
    tag = "R7";
    drive(1'b0, 1'b0, 3);
    chk("R7", cmp_o, 1'b1, "compat pulse");
    drive(1'b1, 1'b1, 5);
    drive(1'b0, 1'b0, 3);
    chk("R7", cmp_o, 1'b1, "compat with select fall");
    drive(1'b0, 1'b1, 5);
    // R11: strobes keep working while flag is high
    tag = "R11";
    drive(1'b1, 1'b0, 5);
    drive(1'b0, 1'b1, 5);
    drive(1'b0, 1'b0, 3);
    chk("R11", cmp_o, 1'b1, "compat while flagged");
    chk("R11", flag_o, 1'b1, "flag still set");
    drive(1'b0, 1'b1, 5);
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    // random phase
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      int r;
      logic na, nb;
      r  = $urandom % 8;
      na = sel_i; nb = strb_i;
      if (r < 3)       na = ~na;
      else if (r < 6)  nb = ~nb;
      else if (r == 6) begin na = ~na; nb = ~nb; end
      clr_i = (($urandom % 10) == 0);
      sel_i = na; strb_i = nb;
      @(negedge clk);
      clr_i = 1'b0;
      repeat ($urandom % 5) @(negedge clk);
    end
    drive(sel_i, strb_i, 5);
    finish_run();
  end

endmodule